// File: doc/BRIEF.md
# Keyed Amplitude Shaper

This block scales a signed sample stream by a 14-bit amplitude factor so that bursts can be switched on and off with controlled edges instead of abrupt steps. In auto mode an internal amplitude counter climbs in straight-line steps toward a programmed ceiling while an external keying pin is high. It falls back toward zero while the pin is low. A ramp-rate prescaler sets how often the counter moves, and a two-bit code sets the size of each step.

In manual mode the programmed 14-bit amplitude is applied directly, and the keying pin and ramp settings have no effect. With the keying enable low the block is bypassed: samples pass through unscaled, and both the control word and the ramp rate are ignored. This is the state after reset.

The control word is 16 bits wide. Its two top bits carry the step code, and its low 14 bits carry the amplitude, which acts as the ceiling in auto mode and as the factor in manual mode. The scaled sample is registered, and the current scale value is available as a separate output.

Top module: `keyed_amp_shaper`

## Requirements
- R1: With `key_en_i` = 0, `sample_o` equals the `sample_i` value of the previous cycle, and `scale_o` reads 16383, whatever the values of `auto_mode_i`, `ctrl_word_i`, `ramp_rate_i` and `key_pin_i`.
- R2: With `key_en_i` = 1 and `auto_mode_i` = 0 (manual mode), `scale_o` equals `ctrl_word_i[13:0]`. Bits 15:14 and `key_pin_i` have no effect.
- R3: With `key_en_i` = 1, `sample_o` equals floor(`sample_i` × `scale_o` / 2^14) for the previous cycle's `sample_i` and `scale_o`, where `sample_i` is taken as two's complement.
- R4: While the block is not in auto mode (`key_en_i` = 0 or `auto_mode_i` = 0), the ramp counter and prescaler are held at zero. On entry to auto mode, `scale_o` therefore starts at 0.
- R5: In auto mode the counter moves on the clock edge that ends every (`ramp_rate_i` + 1)th cycle, counted from the first auto cycle. A rate of 0 moves it on every edge.
- R6: The step size comes from `ctrl_word_i[15:14]`: code 00 gives 1 count, 01 gives 2, 10 gives 4 and 11 gives 8.
- R7: In auto mode, a step with `key_pin_i` = 1 adds the step size but never goes past the ceiling `ctrl_word_i[13:0]`. A step with `key_pin_i` = 0 subtracts the step size but never goes below 0.
- R8: If the ceiling is lowered below the current count, the next upward step lands exactly on the new ceiling.
- R9: Asynchronous active-low reset clears `sample_o`, the ramp counter and the prescaler to 0.
- R10: The direction of each step follows the level of `key_pin_i` in the cycle where that step is taken, even when the pin has just changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_en_i | input | 1 | Shaping enable; 0 bypasses the block |
| auto_mode_i | input | 1 | 1 selects the auto ramp, 0 selects manual scale |
| ctrl_word_i | input | 16 | [15:14] step code, [13:0] amplitude or ceiling |
| ramp_rate_i | input | 8 | Prescaler setting; one step every value+1 cycles |
| key_pin_i | input | 1 | Ramp direction in auto mode: 1 up, 0 down |
| sample_i | input | 16 | Signed input sample |
| sample_o | output | 16 | Registered scaled sample |
| scale_o | output | 14 | Scale factor currently applied |

## Verification
The main overlap to provoke is a prescaler step arriving in the same cycle that the keying pin reverses. The same applies to a step arriving in the cycle the ceiling or the zero floor is reached. The bench sweeps rate, step code and ceiling, toggling the pin every three cycles so that reversals fall on every phase of the prescaler, and uses small ceilings so that saturation and a live step coincide. A cycle-accurate arithmetic model in the bench decides each edge from the pin level and the count held at that edge, and compares both the scale value and the scaled sample in every cycle.

// File: rtl/kas_pkg.sv
package kas_pkg;

  typedef enum logic [1:0] {
    SHAPE_BYPASS = 2'd0,
    SHAPE_MANUAL = 2'd1,
    SHAPE_AUTO   = 2'd2
  } shape_mode_e;

  function automatic shape_mode_e decode_mode(input logic en, input logic auto_sel);
    if (!en)           return SHAPE_BYPASS;
    else if (auto_sel) return SHAPE_AUTO;
    else               return SHAPE_MANUAL;
  endfunction

endpackage

// File: rtl/kas_rate_prescaler.sv
module kas_rate_prescaler #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);

  logic [RATE_W-1:0] div_q;

  // a step is due once the divider has counted rate_i idle cycles
  assign tick_o = run_i && (div_q >= rate_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 div_q <= '0;
    else if (!run_i || tick_o)  div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/kas_ramp_counter.sv
module kas_ramp_counter #(
  parameter int AMP_W = 14,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             up_i,
  input  logic [SEL_W-1:0] step_sel_i,
  input  logic [AMP_W-1:0] ceil_i,
  output logic [AMP_W-1:0] amp_o
);

  localparam int SUM_W = AMP_W + 1;

  logic [AMP_W-1:0] amp_q;
  logic [AMP_W-1:0] amp_next;

  function automatic logic [SUM_W-1:0] step_of(input logic [SEL_W-1:0] sel);
    return SUM_W'(1) << sel;
  endfunction

  function automatic logic [AMP_W-1:0] advance(
    input logic [AMP_W-1:0] cur,
    input logic [SUM_W-1:0] step,
    input logic [AMP_W-1:0] ceil,
    input logic             up
  );
    logic [SUM_W-1:0] sum;
    sum = {1'b0, cur} + step;
    if (up) begin
      if (sum > {1'b0, ceil}) return ceil;
      else                    return sum[AMP_W-1:0];
    end else begin
      if ({1'b0, cur} <= step) return '0;
      else                     return cur - step[AMP_W-1:0];
    end
  endfunction

  assign amp_next = advance(amp_q, step_of(step_sel_i), ceil_i, up_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      amp_q <= '0;
    else if (!run_i) amp_q <= '0;
    else if (tick_i) amp_q <= amp_next;
  end

  assign amp_o = amp_q;

endmodule

// File: rtl/kas_sample_scaler.sv
module kas_sample_scaler #(
  parameter int SAMPLE_W = 16,
  parameter int AMP_W    = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bypass_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic        [AMP_W-1:0]    scale_i,
  output logic signed [SAMPLE_W-1:0] sample_o
);

  localparam int PROD_W = SAMPLE_W + AMP_W + 1;

  logic signed [SAMPLE_W-1:0] scaled;

  function automatic logic signed [SAMPLE_W-1:0] apply_scale(
    input logic signed [SAMPLE_W-1:0] s,
    input logic        [AMP_W-1:0]    k
  );
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    prod    = PROD_W'(s) * PROD_W'($signed({1'b0, k}));
    shifted = prod >>> AMP_W;
    return shifted[SAMPLE_W-1:0];
  endfunction

  assign scaled = apply_scale(sample_i, scale_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sample_o <= '0;
    else if (bypass_i) sample_o <= sample_i;
    else               sample_o <= scaled;
  end

endmodule

// File: rtl/keyed_amp_shaper.sv
module keyed_amp_shaper
  import kas_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int AMP_W    = 14,
  parameter int SEL_W    = 2,
  parameter int RATE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       key_en_i,
  input  logic                       auto_mode_i,
  input  logic [SEL_W+AMP_W-1:0]     ctrl_word_i,
  input  logic [RATE_W-1:0]          ramp_rate_i,
  input  logic                       key_pin_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic [AMP_W-1:0]           scale_o
);

  localparam int WORD_W = SEL_W + AMP_W;

  shape_mode_e      mode;
  logic             auto_run;
  logic             step_tick;
  logic [AMP_W-1:0] amp_level;
  logic [AMP_W-1:0] amp_field;
  logic [SEL_W-1:0] step_sel;
  logic             bypass;

  assign mode      = decode_mode(key_en_i, auto_mode_i);
  assign auto_run  = (mode == SHAPE_AUTO);
  assign bypass    = (mode == SHAPE_BYPASS);
  assign amp_field = ctrl_word_i[AMP_W-1:0];
  assign step_sel  = ctrl_word_i[WORD_W-1:AMP_W];

  kas_rate_prescaler #(.RATE_W(RATE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (auto_run),
    .rate_i (ramp_rate_i),
    .tick_o (step_tick)
  );

  kas_ramp_counter #(.AMP_W(AMP_W), .SEL_W(SEL_W)) u_ramp (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (auto_run),
    .tick_i     (step_tick),
    .up_i       (key_pin_i),
    .step_sel_i (step_sel),
    .ceil_i     (amp_field),
    .amp_o      (amp_level)
  );

  always_comb begin
    unique case (mode)
      SHAPE_AUTO:   scale_o = amp_level;
      SHAPE_MANUAL: scale_o = amp_field;
      default:      scale_o = '1;
    endcase
  end

  kas_sample_scaler #(.SAMPLE_W(SAMPLE_W), .AMP_W(AMP_W)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .bypass_i (bypass),
    .sample_i (sample_i),
    .scale_i  (scale_o),
    .sample_o (sample_o)
  );

endmodule

// File: rtl/kas_checker.sv
module kas_checker #(
  parameter int SAMPLE_W = 16,
  parameter int AMP_W    = 14
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       key_en_i,
  input logic                       key_pin_i,
  input logic                       auto_run,
  input logic                       step_tick,
  input logic [AMP_W-1:0]           amp_level,
  input logic signed [SAMPLE_W-1:0] sample_i,
  input logic signed [SAMPLE_W-1:0] sample_o
);

  // R1
  bypass_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_en_i |=> (sample_o == $past(sample_i)));

  // R4
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_run |=> (amp_level == '0));

  // R5
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_run && !step_tick) |=> $stable(amp_level));

  // R5
  tick_only_in_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_tick |-> auto_run);

  // R7
  floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_tick && !key_pin_i && amp_level == '0) |=> (amp_level == '0));

endmodule

bind keyed_amp_shaper kas_checker #(.SAMPLE_W(SAMPLE_W), .AMP_W(AMP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .key_en_i  (key_en_i),
  .key_pin_i (key_pin_i),
  .auto_run  (auto_run),
  .step_tick (step_tick),
  .amp_level (amp_level),
  .sample_i  (sample_i),
  .sample_o  (sample_o)
);

// File: tb/sim_keyed_amp_shaper.sv
module sim_keyed_amp_shaper;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic               key_en = 1'b0;
  logic               auto_mode = 1'b0;
  logic               key_pin = 1'b0;
  logic [15:0]        word = '0;
  logic [7:0]         rate = '0;
  logic signed [15:0] smp = '0;
  logic signed [15:0] smp_o;
  logic [13:0]        scale_o;

  int vec = 0;
  int bad = 0;
  int m_amp = 0;
  int m_cnt = 0;
  int seed = 7;
  bit done = 0;

  keyed_amp_shaper u0 (
    .clk(clk), .rst_n(rst_n), .key_en_i(key_en), .auto_mode_i(auto_mode),
    .ctrl_word_i(word), .ramp_rate_i(rate), .key_pin_i(key_pin),
    .sample_i(smp), .sample_o(smp_o), .scale_o(scale_o)
  );

  task automatic check(string req, int act, int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic next_sample(int i);
    seed = seed * 1103515245 + 12345;
    if (i % 17 == 0)      smp = 16'sh7fff;
    else if (i % 17 == 8) smp = 16'sh8000;
    else                  smp = 16'(seed >>> 9);
  endtask

  function automatic int model_scale();
    if (!key_en)    return 16383;
    if (!auto_mode) return int'(word[13:0]);
    return m_amp;
  endfunction

  // one clock: inputs already set at a falling edge
  task automatic cycle(string req);
    int sc, exp_s, st, ceil;
    bit tick;
    #1;
    sc = model_scale();
    check(req, int'(scale_o), sc);
    exp_s = key_en ? ((int'(smp) * sc) >>> 14) : int'(smp);
    if (!(key_en && auto_mode)) begin
      m_cnt = 0;
      m_amp = 0;
    end else begin
      tick  = (m_cnt >= int'(rate));
      m_cnt = tick ? 0 : m_cnt + 1;
      if (tick) begin
        st   = 1 << word[15:14];
        ceil = int'(word[13:0]);
        if (key_pin) m_amp = (m_amp + st > ceil) ? ceil : m_amp + st;
        else         m_amp = (m_amp <= st) ? 0 : m_amp - st;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check({req, "/R3"}, int'(smp_o), exp_s);
  endtask

  task automatic run(string req, int n, bit pin);
    for (int i = 0; i < n; i++) begin
      key_pin = pin;
      next_sample(i);
      cycle(req);
    end
  endtask

  initial begin
    #(20 * 190000);
    bad++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    end
    $finish;
  end

  initial begin
    int rates[4] = '{0, 1, 2, 5};
    int ceils[4] = '{0, 3, 37, 300};
    int mvals[5] = '{0, 1, 8191, 16383, 12345};

    // R9 reset state
    @(negedge clk);
    check("R9", int'(smp_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 bypass: other controls ignored
    for (int i = 0; i < 200; i++) begin
      key_en = 1'b0;
      auto_mode = i[0];
      word = 16'(i * 977);
      rate = 8'(i * 13);
      key_pin = i[1];
      next_sample(i);
      cycle("R1");
    end

    // R4 entry into auto starts from zero, R2 manual mode
    key_en = 1'b1;
    foreach (mvals[v]) begin
      for (int code = 0; code < 4; code++) begin
        auto_mode = 1'b0;
        word = {2'(code), 14'(mvals[v])};
        run("R2", 2, 1'b1);
        run("R2", 2, 1'b0);
      end
    end

    // R5 R6 R7 R10 sweep over rate, step code and ceiling
    foreach (rates[r]) begin
      for (int code = 0; code < 4; code++) begin
        foreach (ceils[c]) begin
          key_en = 1'b1;
          auto_mode = 1'b1;
          rate = 8'(rates[r]);
          word = {2'(code), 14'(ceils[c])};
          run("R4", 1, 1'b1);
          run("R7", 40, 1'b1);
          run("R7", 15, 1'b0);
          run("R6", 10, 1'b1);
          for (int t = 0; t < 12; t++) run("R10", 3, t[0]);
          run("R5", 40, 1'b0);
          auto_mode = 1'b0;
          run("R4", 2, 1'b1);
        end
      end
    end

    // R6 R7 long ramp to full scale and back
    auto_mode = 1'b1;
    rate = 8'd0;
    word = {2'b11, 14'd16383};
    run("R7", 2100, 1'b1);
    run("R7", 2100, 1'b0);

    // R8 ceiling lowered while above it
    word = {2'b11, 14'd300};
    run("R8", 50, 1'b1);
    word = {2'b11, 14'd100};
    run("R8", 3, 1'b1);
    check("R8", int'(scale_o), 100);

    // R1 leaving auto to bypass
    key_en = 1'b0;
    run("R1", 4, 1'b1);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    end
    $finish;
  end

endmodule